// File: doc/BRIEF.md
# Threshold Alert Controller for a Die Temperature Monitor

This block sits between a temperature sensor's digital result and a processor interrupt line. Software starts the monitor through a run bit. It selects the temperature function through a 4-bit mode field and keeps a repeat setting for endless periodic sampling. It then programs up to three alert channels. Each channel has its own enable bit and an 8-bit threshold in whole degrees Celsius.

A strobe with a 9-bit two's-complement reading stands in for the sensor. While the monitor is running in temperature mode and its start-up settling window has passed, every strobe is stored as the latest result. Every enabled channel whose threshold is at or below the reading raises a sticky status bit.

One interrupt control word carries the per-channel interrupt enable, status and write-one-to-clear bits, four bit positions apart. The interrupt output stays high while any enabled status remains. Settling after a start, and hold-off after a stop, are counted in clock cycles. This lets the hardware itself reject early samples and early restarts.

Top module: `tmon_alert_top`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Byte offsets: run 0x00 (bit 0), mode 0x04 (bits 3:0), repeat 0x08 (endless flag bit 24, period bits 3:0), result 0x0C (read-only), alert channel n at 0x10 + 4·n (enable bit 0, threshold bits 23:16), interrupt control 0x20. Only these bits hold data. All other bits read 0. A register changes only on a write to it.
- R3: A strobe on `smp_valid` is accepted only while the run bit is 1, mode equals 0x5, and the settling window is over. An accepted strobe puts `smp_code` into bits 8:0 of the result register. Strobes arriving under any other condition leave the result and the status bits unchanged.
- R4: When the run bit goes from 0 to 1 on a write at clock edge E, the strobes at edges E+1 through E+SETTLE_CYC are ignored. The strobe at edge E+SETTLE_CYC+1 is accepted.
- R5: When the run bit goes from 1 to 0 on a write at edge D, a write of 1 to it at edges D+1 through D+RESTART_CYC is ignored and the bit stays 0. The first write after that window starts the monitor.
- R6: An accepted strobe sets the status bit (interrupt control bit 4n+1) of every enabled channel n whose unsigned threshold is less than or equal to the signed reading. A negative reading never trips a channel.
- R7: A channel with its enable bit at 0 never sets its status, whatever the reading.
- R8: Writing 1 to bit 4n+2 of interrupt control clears status n. Clear bits always read 0. Writes to status bits have no effect. When a trip and a clear of the same channel happen in one cycle, the status stays set.
- R9: `irq` is high exactly when some channel has both its status and its interrupt enable (bit 4n) set. It stays high until software clears those statuses or masks them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register accessed; word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| smp_valid | input | 1 | Sensor result strobe |
| smp_code | input | 9 | Sensor reading, two's complement, whole degrees |
| irq | output | 1 | Alert interrupt |

## Verification
The comparison is swept over all 512 reading codes against two sets of thresholds. The first set uses 0, 127 and 255, so the edges of both the signed and the unsigned ranges are covered. The second set includes a disabled channel, which tells a real enable gate apart from a bare comparator and confirms that negative codes never trip a channel.

Strobes are also placed on exactly the last ignored edge and the first accepted edge of the settling window. Restart writes are placed on both sides of the hold-off window, which exposes any off-by-one error in the counters.

Further directed patterns each isolate one behaviour:
- a strobe before the monitor is run;
- a strobe in a non-temperature mode;
- a strobe with a low reading after a trip, which must leave the status sticky;
- an interrupt enable that is masked and then unmasked;
- a clear that lands in the same cycle as a trip.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    localparam int NUM_CH     = 3;
    localparam int DATA_W     = 32;
    localparam int CODE_W     = 9;
    localparam int THR_W      = 8;
    localparam int MODE_W     = 4;
    localparam int PER_W      = 4;

    localparam logic [MODE_W-1:0] MODE_TEMP = 4'h5;

    // bit positions that software relies on
    localparam int LOOP_BIT   = 24;
    localparam int THR_LSB    = 16;
    localparam int CH_EN_BIT  = 0;
    localparam int IRQ_STRIDE = 4;
    localparam int IEN_OFS    = 0;
    localparam int STAT_OFS   = 1;
    localparam int CLR_OFS    = 2;

    // word indices (byte offset / 4)
    localparam int W_RUN   = 0;
    localparam int W_MODE  = 1;
    localparam int W_RPT   = 2;
    localparam int W_RES   = 3;
    localparam int W_ALERT = 4;
    localparam int W_INT   = 8;

    typedef struct packed {
        logic              en;
        logic [THR_W-1:0]  thr;
    } alert_cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_RUN, SEL_MODE, SEL_RPT, SEL_RES, SEL_ALERT, SEL_INT
    } reg_sel_e;

    function automatic reg_sel_e decode_word(input int unsigned word, input logic misaligned);
        reg_sel_e s;
        s = SEL_NONE;
        if (!misaligned) begin
            if (word == W_RUN)       s = SEL_RUN;
            else if (word == W_MODE) s = SEL_MODE;
            else if (word == W_RPT)  s = SEL_RPT;
            else if (word == W_RES)  s = SEL_RES;
            else if (word == W_INT)  s = SEL_INT;
            else if (word >= W_ALERT && word < W_ALERT + NUM_CH) s = SEL_ALERT;
        end
        return s;
    endfunction

    // unsigned threshold against signed reading
    function automatic logic reaches_threshold(input logic [THR_W-1:0] thr,
                                               input logic [CODE_W-1:0] code);
        logic signed [CODE_W:0] r;
        logic signed [CODE_W:0] t;
        r = $signed({code[CODE_W-1], code});
        t = $signed({{(CODE_W-THR_W+1){1'b0}}, thr});
        return r >= t;
    endfunction
endpackage

// File: rtl/tmon_seq.sv
module tmon_seq
    import tmon_pkg::*;
#(
    parameter int SETTLE_CYC  = 35000,
    parameter int RESTART_CYC = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_wr,
    input  logic run_wval,
    input  logic mode_ok,
    output logic run_q,
    output logic accept_en
);
    localparam int MAX_CYC = (SETTLE_CYC > RESTART_CYC) ? SETTLE_CYC : RESTART_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] SETTLE_V  = CNT_W'(SETTLE_CYC);
    localparam logic [CNT_W-1:0] RESTART_V = CNT_W'(RESTART_CYC);

    logic [CNT_W-1:0] settle_q;
    logic [CNT_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            settle_q <= '0;
            hold_q   <= '0;
        end else begin
            if (settle_q != '0) settle_q <= settle_q - 1'b1;
            if (hold_q != '0)   hold_q   <= hold_q - 1'b1;
            if (run_wr) begin
                if (run_wval && !run_q && hold_q == '0) begin
                    run_q    <= 1'b1;
                    settle_q <= SETTLE_V;
                end else if (!run_wval && run_q) begin
                    run_q    <= 1'b0;
                    settle_q <= '0;
                    hold_q   <= RESTART_V;
                end
            end
        end
    end

    assign accept_en = run_q && mode_ok && (settle_q == '0);

    AST_START_LOADS_SETTLE: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> settle_q == SETTLE_V); // R4
    AST_HOLDOFF_BLOCKS_RUN: assert property (@(posedge clk) disable iff (rst)
        (hold_q != '0 && !run_q) |=> !run_q); // R5
endmodule

// File: rtl/tmon_regfile.sv
module tmon_regfile
    import tmon_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  reg_sel_e                sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [MODE_W-1:0]       mode,
    output logic                    rpt_loop,
    output logic [PER_W-1:0]        rpt_period,
    output alert_cfg_t [NUM_CH-1:0] cfg,
    output logic [NUM_CH-1:0]       ien,
    output logic [NUM_CH-1:0]       clr,
    output logic                    run_wr,
    output logic                    run_wval
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    assign run_wr   = wr && (sel == SEL_RUN);
    assign run_wval = wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= '0;
            rpt_loop   <= 1'b0;
            rpt_period <= '0;
        end else if (wr) begin
            if (sel == SEL_MODE) mode <= wdata[MODE_W-1:0];
            if (sel == SEL_RPT) begin
                rpt_loop   <= wdata[LOOP_BIT];
                rpt_period <= wdata[PER_W-1:0];
            end
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(W_ALERT + n);
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[n] <= '0;
                ien[n] <= 1'b0;
            end else if (wr) begin
                if (sel == SEL_ALERT && word == MY_WORD) begin
                    cfg[n].en  <= wdata[CH_EN_BIT];
                    cfg[n].thr <= wdata[THR_LSB +: THR_W];
                end
                if (sel == SEL_INT) ien[n] <= wdata[IRQ_STRIDE*n + IEN_OFS];
            end
        end
        assign clr[n] = wr && (sel == SEL_INT) && wdata[IRQ_STRIDE*n + CLR_OFS];
    end

    AST_MODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(mode)); // R2
endmodule

// File: rtl/tmon_alert_chan.sv
module tmon_alert_chan
    import tmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_ok,
    input  logic [CODE_W-1:0] code,
    input  alert_cfg_t        cfg,
    input  logic              clr,
    output logic              status
);
    logic hit;
    assign hit = sample_ok && cfg.en && reaches_threshold(cfg.thr, code);

    always_ff @(posedge clk) begin
        if (rst)      status <= 1'b0;
        else if (hit) status <= 1'b1;   // a trip outranks a clear
        else if (clr) status <= 1'b0;
    end

    AST_STATUS_NEEDS_TRIP: assert property (@(posedge clk) disable iff (rst)
        (!status && (!sample_ok || !cfg.en)) |=> !status); // R7
    AST_CLEAR_DROPS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (status && clr && !sample_ok) |=> !status); // R8
endmodule

// File: rtl/tmon_alert_top.sv
module tmon_alert_top
    import tmon_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SETTLE_CYC  = 35000,
    parameter int RESTART_CYC = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              smp_valid,
    input  logic [8:0]        smp_code,
    output logic              irq
);
    reg_sel_e                sel;
    logic [MODE_W-1:0]       mode;
    logic                    rpt_loop;
    logic [PER_W-1:0]        rpt_period;
    alert_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]       ien;
    logic [NUM_CH-1:0]       clr;
    logic [NUM_CH-1:0]       status;
    logic                    run_wr;
    logic                    run_wval;
    logic                    run_q;
    logic                    accept_en;
    logic                    sample_ok;
    logic [CODE_W-1:0]       result_q;

    assign sel = decode_word(int'(bus_addr[ADDR_W-1:2]), bus_addr[1:0] != 2'b00);

    tmon_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .addr(bus_addr),
        .wdata(bus_wdata), .mode(mode), .rpt_loop(rpt_loop),
        .rpt_period(rpt_period), .cfg(cfg), .ien(ien), .clr(clr),
        .run_wr(run_wr), .run_wval(run_wval)
    );

    tmon_seq #(.SETTLE_CYC(SETTLE_CYC), .RESTART_CYC(RESTART_CYC)) u_seq (
        .clk(clk), .rst(rst), .run_wr(run_wr), .run_wval(run_wval),
        .mode_ok(mode == MODE_TEMP), .run_q(run_q), .accept_en(accept_en)
    );

    assign sample_ok = smp_valid && accept_en;

    always_ff @(posedge clk) begin
        if (rst)            result_q <= '0;
        else if (sample_ok) result_q <= smp_code;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_alert
        tmon_alert_chan u_chan (
            .clk(clk), .rst(rst), .sample_ok(sample_ok), .code(smp_code),
            .cfg(cfg[n]), .clr(clr[n]), .status(status[n])
        );
    end

    assign irq = |(status & ien);

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_RUN:  bus_rdata[0] = run_q;
            SEL_MODE: bus_rdata[MODE_W-1:0] = mode;
            SEL_RPT: begin
                bus_rdata[LOOP_BIT]  = rpt_loop;
                bus_rdata[PER_W-1:0] = rpt_period;
            end
            SEL_RES:  bus_rdata[CODE_W-1:0] = result_q;
            SEL_ALERT: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    if (int'(bus_addr[ADDR_W-1:2]) == W_ALERT + n) begin
                        bus_rdata[CH_EN_BIT]          = cfg[n].en;
                        bus_rdata[THR_LSB +: THR_W]   = cfg[n].thr;
                    end
                end
            end
            SEL_INT: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    bus_rdata[IRQ_STRIDE*n + IEN_OFS]  = ien[n];
                    bus_rdata[IRQ_STRIDE*n + STAT_OFS] = status[n];
                end
            end
            default: bus_rdata = '0;
        endcase
    end

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !sample_ok |=> $stable(result_q)); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !bus_wr) |=> irq); // R9
endmodule

// File: tb/tmon_alert_top_bench.sv
`timescale 1ns/1ps
module tmon_alert_top_bench;
    localparam int S = 20;
    localparam int R = 30;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        smp_valid;
    logic [8:0]  smp_code;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    tmon_alert_top #(.ADDR_W(8), .SETTLE_CYC(S), .RESTART_CYC(R)) u_tmon_alert_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
        .smp_code(smp_code), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic sample(input logic [8:0] c);
        smp_valid = 1'b1; smp_code = c;
        @(posedge clk); @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic sample_and_clear(input logic [8:0] c, input logic [31:0] d);
        smp_valid = 1'b1; smp_code = c;
        bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        smp_valid = 1'b0; bus_wr = 1'b0;
    endtask

    function automatic logic trips(input int thr, input int code);
        int s;
        s = (code >= 256) ? code - 512 : code;
        return s >= thr;
    endfunction

    task automatic sweep(input int t0, input int t1, input int t2, input logic en2);
        logic [31:0] v;
        logic [31:0] exp;
        wr(8'h10, (t0 << 16) | 1);
        wr(8'h14, (t1 << 16) | 1);
        wr(8'h18, (t2 << 16) | 32'(en2));
        for (int c = 0; c < 512; c++) begin
            sample(9'(c));
            rd(8'h0C, v);
            check("R3 result", v, 32'(c));
            exp = 32'h111;
            if (trips(t0, c))        exp |= 32'h002;
            if (trips(t1, c))        exp |= 32'h020;
            if (en2 && trips(t2, c)) exp |= 32'h200;
            rd(8'h20, v);
            check(en2 ? "R6 sweep" : "R7 sweep", v, exp);
            check("R9 irq sweep", 32'(irq), 32'(exp != 32'h111));
            wr(8'h20, 32'h555);
        end
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        smp_valid = 1'b0; smp_code = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        for (int a = 0; a <= 8; a++) begin
            rd(8'(a * 4), v);
            check("R1 reset reg", v, 0);
        end
        check("R1 irq", 32'(irq), 0);

        // R2: implemented bits only
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R2 mode", v, 32'h0000_000F);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); check("R2 repeat", v, 32'h0100_000F);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); check("R2 alert2", v, 32'h00FF_0001);
        rd(8'h14, v); check("R2 alert1 untouched", v, 0);
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); check("R8 status not writable", v, 32'h111);

        // setup
        wr(8'h04, 32'h5);
        wr(8'h10, (30 << 16) | 1);
        wr(8'h14, (100 << 16) | 1);
        wr(8'h18, 32'h0);

        // R3: not running
        sample(9'd40);
        rd(8'h0C, v); check("R3 idle result", v, 0);
        rd(8'h20, v); check("R3 idle status", v, 32'h111);

        // R4: settling boundary
        wr(8'h00, 32'h1);
        idle(S - 1);
        sample(9'd77);
        rd(8'h0C, v); check("R4 last ignored", v, 0);
        sample(9'd77);
        rd(8'h0C, v); check("R4 first accepted", v, 77);
        rd(8'h20, v); check("R6 trip ch0", v, 32'h113);
        check("R9 irq up", 32'(irq), 1);

        // R9: mask / unmask
        wr(8'h20, 32'h110);
        rd(8'h20, v); check("R9 masked status", v, 32'h112);
        check("R9 masked irq", 32'(irq), 0);
        wr(8'h20, 32'h111);
        check("R9 unmasked irq", 32'(irq), 1);
        idle(4);
        sample(9'd10);
        check("R9 sticky irq", 32'(irq), 1);

        // R8: clear, and trip wins over clear
        wr(8'h20, 32'h115);
        rd(8'h20, v); check("R8 cleared", v, 32'h111);
        check("R8 irq low", 32'(irq), 0);
        sample_and_clear(9'd77, 32'h115);
        rd(8'h20, v); check("R8 trip beats clear", v, 32'h113);
        wr(8'h20, 32'h555);

        // R3: wrong mode
        wr(8'h04, 32'h3);
        sample(9'd200);
        rd(8'h0C, v); check("R3 mode gate result", v, 77);
        rd(8'h20, v); check("R3 mode gate status", v, 32'h111);
        wr(8'h04, 32'h5);

        // R6 / R7 sweeps
        sweep(0, 127, 255, 1'b1);
        sweep(64, 200, 1, 1'b0);

        // R5: restart hold-off boundary
        wr(8'h00, 32'h0);
        idle(R - 1);
        wr(8'h00, 32'h1);
        rd(8'h00, v); check("R5 early restart ignored", v, 0);
        wr(8'h00, 32'h1);
        rd(8'h00, v); check("R5 restart accepted", v, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule